// File: doc/BRIEF.md
# Font Row and Column Indexer

This block turns the raster position of a character display into the coordinates used to address a font glyph. Each font pixel is drawn two screen pixels wide and three screen lines tall. The column coordinate is the horizontal pixel count with its lowest bit dropped. It is captured on every pixel-enable cycle inside the active region and forced to zero outside it.

The row coordinate does not come from dividing the line count. A small modulo-3 phase counter counts the line-advance pulses that arrive during active lines. Each time the phase wraps, it steps a 7-bit row counter, which rolls back to zero after 127. A frame-start pulse clears both counters, so every frame begins at row 0. Line pulses in vertical blanking are ignored.

The control half owns the phase counter and sends clear and step strobes to the datapath half, which holds both index registers.

Top module: `fontIndexer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `hIdx` and `vIdx` are both 0.
- R2: On a clock edge where `pixEn` and `hActive` are both 1, `hIdx` takes the value `hCount[8:1]` (the count shifted right by one) from the next cycle.
- R3: On a clock edge where `pixEn` is 1 and `hActive` is 0, `hIdx` becomes 0 from the next cycle.
- R4: On a clock edge where `pixEn` is 0, `hIdx` keeps its value.
- R5: A line pulse (`lineAdv` = 1 with `vActive` = 1 and `frameStart` = 0) advances the phase counter through 0, 1, 2. On the pulse that moves the phase from 2 back to 0, `vIdx` increases by one from the next cycle. After k such pulses since the last frame start, `vIdx` equals floor(k/3) mod 128.
- R6: When `vIdx` is 127 and a line pulse wraps the phase, `vIdx` becomes 0. The 384th line pulse of a frame therefore returns it to 0.
- R7: `frameStart` = 1 clears both the phase counter and `vIdx` from the next cycle. It takes priority over a `lineAdv` pulse in the same cycle.
- R8: `lineAdv` = 1 while `vActive` = 0 changes neither `vIdx` nor the phase. The following three line pulses during active lines therefore behave as if the blanking pulse never happened.
- R9: `vIdx` changes only on the cycle after a `lineAdv` or `frameStart` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | Pixel clock enable |
| hActive | input | 1 | Current pixel lies in the active columns |
| hCount | input | 10 | Horizontal pixel count |
| lineAdv | input | 1 | One-cycle pulse at each line advance |
| frameStart | input | 1 | One-cycle pulse at line 0 of a frame |
| vActive | input | 1 | Current line lies in the active rows |
| hIdx | output | 8 | Font column index |
| vIdx | output | 7 | Font row index |

## Verification
One directed frame feeds 384 active line pulses, with idle gaps between them, after a frame start. Every intermediate row is checked, and the checks at 383 and 384 pulses show that the row wraps at 128 and not at some other power of two. Blanking pulses are placed in the middle of a phase cycle, which tells apart a design that ignores them from one that merely holds `vIdx` while the phase moves on. A frame start is also given together with a line pulse, to expose any wrong priority between the two. A long run of random pixel enables, active flags, counts, line pulses and frame starts then compares both indexes on every cycle against a bench model. This separates the capture, clear and hold paths of the column index and catches any drift of the three-line phase.

// File: rtl/fontIdxPkg.sv
package fontIdxPkg;
  // Strobes from the row control to the index datapath
  typedef struct packed {
    logic clrRow;   // frame start: return row index to zero
    logic stepRow;  // third accepted line: advance row index
  } rowStrb_t;
endpackage

// File: rtl/rowControl.sv
module rowControl
  import fontIdxPkg::*;
#(
  parameter int V_SCALE = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineAdv,
  input  logic     frameStart,
  input  logic     vActive,
  output rowStrb_t strb
);
  localparam int PRE_W = (V_SCALE > 1) ? $clog2(V_SCALE) : 1;

  logic accept;
  logic stepRaw;

  // a line pulse counts only on active lines and never against a frame start
  assign accept = lineAdv & vActive & ~frameStart;

  generate
    if (V_SCALE > 1) begin : gPre
      logic [PRE_W-1:0] phase;
      logic             wrap;

      assign wrap    = (phase == PRE_W'(V_SCALE - 1));
      assign stepRaw = accept & wrap;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           phase <= '0;
        else if (frameStart) phase <= '0;
        else if (accept)     phase <= wrap ? '0 : phase + 1'b1;
      end

      AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        phase <= PRE_W'(V_SCALE - 1)) else $error("phase out of range"); // R5
      AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
        (lineAdv && !vActive && !frameStart) |=> $stable(phase)) else $error("phase moved in blanking"); // R8
    end else begin : gNoPre
      assign stepRaw = accept;
    end
  endgenerate

  assign strb.clrRow  = frameStart;
  assign strb.stepRow = stepRaw;

  AST_NO_STEP_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (lineAdv && !vActive) |-> !strb.stepRow) else $error("step in blanking"); // R8
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clrRow && strb.stepRow)) else $error("clear and step together"); // R7
endmodule

// File: rtl/rowDatapath.sv
module rowDatapath
  import fontIdxPkg::*;
#(
  parameter int H_CNT_W = 10,
  parameter int H_IDX_W = 8,
  parameter int V_ROWS  = 128,
  parameter int V_IDX_W = $clog2(V_ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic               hActive,
  input  logic [H_CNT_W-1:0] hCount,
  input  rowStrb_t           strb,
  output logic [H_IDX_W-1:0] hIdx,
  output logic [V_IDX_W-1:0] vIdx
);
  localparam logic [V_IDX_W-1:0] V_LAST = V_IDX_W'(V_ROWS - 1);

  logic [H_IDX_W-1:0] hHalf;
  assign hHalf = hCount[H_IDX_W:1];

  generate
    if (H_CNT_W > H_IDX_W + 1) begin : gTopBits
      logic unusedHigh;
      assign unusedHigh = ^{hCount[0], hCount[H_CNT_W-1:H_IDX_W+1]};
    end else begin : gNoTopBits
      logic unusedLow;
      assign unusedLow = hCount[0];
    end
  endgenerate

  // column index: two screen pixels per font pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      hIdx <= '0;
    else if (pixEn) hIdx <= hActive ? hHalf : '0;
  end

  // row index: stepped by the control, wraps after the last glyph row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             vIdx <= '0;
    else if (strb.clrRow)  vIdx <= '0;
    else if (strb.stepRow) vIdx <= (vIdx == V_LAST) ? '0 : vIdx + 1'b1;
  end

  AST_H_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && !hActive) |=> (hIdx == '0)) else $error("hIdx not cleared"); // R3
  AST_H_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(hIdx)) else $error("hIdx moved without enable"); // R4
  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRow |=> (vIdx == '0)) else $error("row not cleared"); // R7
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepRow && (vIdx == V_LAST)) |=> (vIdx == '0)) else $error("row wrap wrong"); // R6
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepRow && !strb.clrRow && (vIdx != V_LAST)) |=> (vIdx == $past(vIdx) + 1'b1)) else $error("row step wrong"); // R5
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepRow && !strb.clrRow) |=> $stable(vIdx)) else $error("row moved without strobe"); // R8
endmodule

// File: rtl/fontIndexer.sv
module fontIndexer
  import fontIdxPkg::*;
#(
  parameter int H_CNT_W = 10,
  parameter int H_IDX_W = 8,
  parameter int V_SCALE = 3,
  parameter int V_ROWS  = 128,
  parameter int V_IDX_W = $clog2(V_ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic               hActive,
  input  logic [H_CNT_W-1:0] hCount,
  input  logic               lineAdv,
  input  logic               frameStart,
  input  logic               vActive,
  output logic [H_IDX_W-1:0] hIdx,
  output logic [V_IDX_W-1:0] vIdx
);
  rowStrb_t strb;

  rowControl #(.V_SCALE(V_SCALE)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineAdv    (lineAdv),
    .frameStart (frameStart),
    .vActive    (vActive),
    .strb       (strb)
  );

  rowDatapath #(
    .H_CNT_W (H_CNT_W),
    .H_IDX_W (H_IDX_W),
    .V_ROWS  (V_ROWS),
    .V_IDX_W (V_IDX_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .pixEn   (pixEn),
    .hActive (hActive),
    .hCount  (hCount),
    .strb    (strb),
    .hIdx    (hIdx),
    .vIdx    (vIdx)
  );

  AST_ROW_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!lineAdv && !frameStart) |=> $stable(vIdx)) else $error("vIdx moved without pulse"); // R9
  AST_H_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && hActive) |=> (hIdx == $past(hCount[H_IDX_W:1]))) else $error("hIdx capture wrong"); // R2
endmodule

// File: tb/fontIndexer_test.sv
`timescale 1ns/1ps
module fontIndexer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixEn = 1'b0, hActive = 1'b0, lineAdv = 1'b0, frameStart = 1'b0, vActive = 1'b0;
  logic [9:0] hCount = '0;
  logic [7:0] hIdx;
  logic [6:0] vIdx;

  int checks = 0;
  int errors = 0;
  int phM = 0;
  int vM = 0;
  int hM = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fontIndexer uut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .hActive(hActive), .hCount(hCount),
    .lineAdv(lineAdv), .frameStart(frameStart), .vActive(vActive),
    .hIdx(hIdx), .vIdx(vIdx)
  );

  function automatic int nextV(int v, int ph, bit la, bit fs, bit va);
    if (fs) return 0;
    if (la && va && ph == 2) return (v + 1) % 128;
    return v;
  endfunction

  function automatic int nextPh(int ph, bit la, bit fs, bit va);
    if (fs) return 0;
    if (la && va) return (ph == 2) ? 0 : ph + 1;
    return ph;
  endfunction

  function automatic int nextH(int h, bit pe, bit ha, logic [9:0] hc);
    if (!pe) return h;
    return ha ? int'(hc[8:1]) : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, update model, advance one edge, compare
  task automatic step(bit pe, bit ha, logic [9:0] hc, bit la, bit fs, bit va);
    string vTag, hTag;
    pixEn = pe; hActive = ha; hCount = hc; lineAdv = la; frameStart = fs; vActive = va;
    vM  = nextV(vM, phM, la, fs, va);
    phM = nextPh(phM, la, fs, va);
    hM  = nextH(hM, pe, ha, hc);
    if (fs) vTag = "R7";
    else if (la && va) vTag = "R5";
    else if (la) vTag = "R8";
    else vTag = "R9";
    if (!pe) hTag = "R4"; else if (ha) hTag = "R2"; else hTag = "R3";
    @(posedge clk);
    @(negedge clk);
    check({vTag, " vIdx"}, int'(vIdx), vM);
    check({hTag, " hIdx"}, int'(hIdx), hM);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 hIdx in reset", int'(hIdx), 0);
    check("R1 vIdx in reset", int'(vIdx), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 hIdx after reset", int'(hIdx), 0);
    check("R1 vIdx after reset", int'(vIdx), 0);

    // directed full frame with idle gaps, column sweep alongside
    step(1, 1, 10'd0, 0, 1, 1);
    for (int k = 1; k <= 384; k++) begin
      step(1, 1, 10'(k), 1, 0, 1);
      step(0, 1, 10'(k + 7), 0, 0, 1);
      if (k == 383) check("R6 vIdx at pulse 383", int'(vIdx), 127);
      if (k == 384) check("R6 vIdx wraps to 0 at pulse 384", int'(vIdx), 0);
    end

    // blanking pulse mid-phase must not move the phase
    step(0, 0, 10'd0, 0, 1, 1);
    step(0, 0, 10'd0, 1, 0, 1);
    step(0, 0, 10'd0, 1, 0, 0);
    step(0, 0, 10'd0, 1, 0, 0);
    step(0, 0, 10'd0, 1, 0, 1);
    check("R8 vIdx still 0 after two active pulses", int'(vIdx), 0);
    step(0, 0, 10'd0, 1, 0, 1);
    check("R8 vIdx steps on third active pulse", int'(vIdx), 1);

    // frame start beats a simultaneous line pulse
    step(0, 0, 10'd0, 1, 0, 1);
    step(0, 0, 10'd0, 1, 0, 1);
    step(0, 0, 10'd0, 1, 1, 1);
    check("R7 frame start wins over line pulse", int'(vIdx), 0);
    step(0, 0, 10'd0, 1, 0, 1);
    step(0, 0, 10'd0, 1, 0, 1);
    check("R7 phase cleared by frame start", int'(vIdx), 0);

    // edge column values
    step(1, 1, 10'h3FF, 0, 0, 0);
    check("R2 top count", int'(hIdx), 255);
    step(1, 0, 10'h155, 0, 0, 0);
    check("R3 blank column", int'(hIdx), 0);

    // random traffic
    for (int n = 0; n < 20000; n++) begin
      bit pe, ha, la, fs, va;
      pe = ($urandom % 2) == 0;
      ha = ($urandom % 4) != 0;
      la = ($urandom % 3) == 0;
      fs = ($urandom % 97) == 0;
      va = ($urandom % 4) != 0;
      step(pe, ha, 10'($urandom), la, fs, va);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule